// File: doc/BRIEF.md
# Clock/CMOS Index-Data Access Port

This block is the host path into a clock unit's 256-byte register and battery-backed RAM space. The host uses an 8-bit I/O bus with read and write strobes and an address-enable qualifier. Each bank has two I/O locations: an index location and a data location. The host first writes an index to the index location. Later read or write cycles on the data location then reach the byte that index selects.

There are two banks. The primary bank sits at fixed I/O 0070h (index) and 0071h (data) and covers bytes 0 to 127. The secondary bank sits at a relocatable base and base+1. It is enabled by a mode bit and covers bytes 128 to 255. The block also drives the address, the strobes and the write data toward the storage, and it carries the read data back. A plain 256-byte register array stands in for the timekeeping registers. While the system reset is asserted, the storage cannot be reached.

Top module: `rtc_index_port`

## Requirements
- R1: A write strobe on a bank's index location latches bits 6:0 of the bus data as that bank's index. Bit 7 is discarded, so a later read of the index location returns it as 0.
- R2: A read strobe on a decoded location raises `io_oe_o` in that same cycle, with the data on `io_rdata_o`. A read strobe on a data location returns the byte selected by that bank's index. A read strobe on an index location returns the index, zero-extended. With no decoded read strobe, `io_oe_o` is 0.
- R3: A write strobe on a data location stores the bus byte at the selected address. The index does not move after a data access: repeated data cycles reach the same byte.
- R4: The primary bank decodes the full 16-bit I/O address: 0070h is the index location and 0071h is the data location. Addresses that differ in any upper bit are not decoded.
- R5: The secondary bank decodes at {base_hi, base_lo} (index) and that value plus 1 (data), but only while `bank1_en_i` is 1. Its index selects storage address 128 + index.
- R6: While `aen_i` is 1, no location decodes. No index changes, no byte is stored, and `io_oe_o` stays 0.
- R7: While `sys_rst_i` is 1, writes to any location are dropped. Decoded reads return FFh with `io_oe_o` high. No storage strobe is issued.
- R8: If the secondary window overlaps 0070h or 0071h, the primary bank wins the overlapping location.
- R9: After `rst_ni`, both indices are 0 and every storage byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_rst_i | input | 1 | System reset; blocks all storage and index access |
| aen_i | input | 1 | Address-enable qualifier; high marks a non-host cycle |
| io_addr_i | input | 16 | I/O address |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_wdata_i | input | 8 | Write data from the host |
| io_rdata_o | output | 8 | Read data to the host, valid while io_oe_o is high |
| io_oe_o | output | 1 | Bus drive enable for read data |
| bank1_en_i | input | 1 | Secondary bank enable |
| bank1_base_hi_i | input | 8 | Secondary base, upper byte |
| bank1_base_lo_i | input | 8 | Secondary base, lower byte |
| mem_addr_o | output | 8 | Storage byte address |
| mem_rd_o | output | 1 | Storage read strobe |
| mem_wr_o | output | 1 | Storage write strobe |
| mem_wdata_o | output | 8 | Storage write data |

## Verification
A corrupted index shows up on the first read of its index location. It also shows up on the first data read, which returns the wrong byte, so either error is visible one access after the bad latch. A wrong decode, bank priority or qualifier term shows up as a write landing in the wrong byte. It can also show up as a drive enable asserted on a cycle it should ignore. Each stimulus is therefore followed by reads through both banks. The bench also checks that the secondary bank's data never aliases the primary bank's bytes.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDX0,
    SEL_DAT0,
    SEL_IDX1,
    SEL_DAT1
  } port_sel_e;

  function automatic logic sel_is_data(port_sel_e s);
    return (s == SEL_DAT0) || (s == SEL_DAT1);
  endfunction

  function automatic logic sel_is_index(port_sel_e s);
    return (s == SEL_IDX0) || (s == SEL_IDX1);
  endfunction

  function automatic logic sel_bank(port_sel_e s);
    return (s == SEL_IDX1) || (s == SEL_DAT1);
  endfunction
endpackage

// File: rtl/rtc_io_decode.sv
module rtc_io_decode
  import rtc_port_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 16'h0070
) (
  input  logic              aen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank1_en_i,
  input  logic [ADDR_W-1:0] bank1_base_i,
  output port_sel_e         sel_o
);
  localparam logic [ADDR_W-1:0] BANK0_DATA = BANK0_BASE + ADDR_W'(1);

  logic [ADDR_W-1:0] bank1_data;
  logic hit_i0, hit_d0, hit_i1, hit_d1;

  assign bank1_data = bank1_base_i + ADDR_W'(1);

  always_comb begin
    hit_i0 = !aen_i && (addr_i == BANK0_BASE);
    hit_d0 = !aen_i && (addr_i == BANK0_DATA);
    hit_i1 = !aen_i && bank1_en_i && (addr_i == bank1_base_i);
    hit_d1 = !aen_i && bank1_en_i && (addr_i == bank1_data);
  end

  // primary bank has priority on overlap
  always_comb begin
    if (hit_i0)      sel_o = SEL_IDX0;
    else if (hit_d0) sel_o = SEL_DAT0;
    else if (hit_i1) sel_o = SEL_IDX1;
    else if (hit_d1) sel_o = SEL_DAT1;
    else             sel_o = SEL_NONE;
  end
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned NBANK = 2,
  localparam int unsigned BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [BSEL_W-1:0]           bank_i,
  input  logic [IDX_W-1:0]            wdata_i,
  output logic [NBANK-1:0][IDX_W-1:0] idx_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [IDX_W-1:0] idx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 idx_q <= '0;
      else if (we_i && (bank_i == BSEL_W'(b)))     idx_q <= wdata_i;
    end
    assign idx_o[b] = idx_q;
  end
endmodule

// File: rtl/rtc_cmos_array.sv
module rtc_cmos_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 7,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 16'h0070,
  parameter logic [DATA_W-1:0] BLOCKED_FILL = 8'hFF,
  localparam int unsigned NBANK = 2,
  localparam int unsigned MEM_AW = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              aen_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_oe_o,
  input  logic              bank1_en_i,
  input  logic [7:0]        bank1_base_hi_i,
  input  logic [7:0]        bank1_base_lo_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  port_sel_e                   sel;
  logic [ADDR_W-1:0]           bank1_base;
  logic                        bank;
  logic                        is_data, is_index, access_ok;
  logic                        idx_we;
  logic [NBANK-1:0][IDX_W-1:0] idx_q;
  logic [IDX_W-1:0]            idx_cur;
  logic [DATA_W-1:0]           mem_rdata;

  assign bank1_base = ADDR_W'({bank1_base_hi_i, bank1_base_lo_i});

  rtc_io_decode #(
    .ADDR_W    (ADDR_W),
    .BANK0_BASE(BANK0_BASE)
  ) u_decode (
    .aen_i       (aen_i),
    .addr_i      (io_addr_i),
    .bank1_en_i  (bank1_en_i),
    .bank1_base_i(bank1_base),
    .sel_o       (sel)
  );

  assign bank      = sel_bank(sel);
  assign is_data   = sel_is_data(sel);
  assign is_index  = sel_is_index(sel);
  assign access_ok = !sys_rst_i;
  assign idx_we    = io_wr_i && is_index && access_ok;

  rtc_index_regs #(
    .IDX_W(IDX_W),
    .NBANK(NBANK)
  ) u_index (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (idx_we),
    .bank_i (bank),
    .wdata_i(io_wdata_i[IDX_W-1:0]),
    .idx_o  (idx_q)
  );

  assign idx_cur     = idx_q[bank];
  assign mem_addr_o  = {bank, idx_cur};
  assign mem_wr_o    = io_wr_i && is_data && access_ok;
  assign mem_rd_o    = io_rd_i && is_data && access_ok;
  assign mem_wdata_o = io_wdata_i;

  rtc_cmos_array #(
    .DATA_W(DATA_W),
    .AW    (MEM_AW)
  ) u_cmos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_wr_o),
    .addr_i (mem_addr_o),
    .wdata_i(mem_wdata_o),
    .rdata_o(mem_rdata)
  );

  always_comb begin
    io_oe_o    = io_rd_i && (sel != SEL_NONE);
    io_rdata_o = '0;
    if (io_oe_o) begin
      if (!access_ok)    io_rdata_o = BLOCKED_FILL;
      else if (is_data)  io_rdata_o = mem_rdata;
      else               io_rdata_o = DATA_W'(idx_cur);
    end
  end
endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_i,
  input logic              aen_i,
  input logic [15:0]       io_addr_i,
  input logic              io_rd_i,
  input logic              io_wr_i,
  input logic              io_oe_o,
  input logic [DATA_W-1:0] io_rdata_o,
  input logic              mem_wr_o,
  input logic              mem_rd_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [1:0][IDX_W-1:0] idx_q
);
  assert_oe_needs_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> io_rd_i);

  assert_aen_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> !io_oe_o && !mem_wr_o && !mem_rd_o);

  assert_sysrst_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |-> !mem_wr_o && !mem_rd_o);

  assert_sysrst_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && io_oe_o) |-> io_rdata_o == 8'hFF);

  assert_index_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && !aen_i && !sys_rst_i) |=> $stable(idx_q));

  assert_bank0_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && io_addr_i == 16'h0071) |-> !mem_addr_o[MEM_AW-1]);
endmodule

bind rtc_index_port rtc_index_port_chk #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W),
  .MEM_AW(MEM_AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_i (sys_rst_i),
  .aen_i     (aen_i),
  .io_addr_i (io_addr_i),
  .io_rd_i   (io_rd_i),
  .io_wr_i   (io_wr_i),
  .io_oe_o   (io_oe_o),
  .io_rdata_o(io_rdata_o),
  .mem_wr_o  (mem_wr_o),
  .mem_rd_o  (mem_rd_o),
  .mem_addr_o(mem_addr_o),
  .idx_q     (idx_q)
);

// File: tb/rtc_index_port_test.sv
module rtc_index_port_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic        aen_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_rd_i = 1'b0;
  logic        io_wr_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        io_oe_o;
  logic        bank1_en_i = 1'b0;
  logic [7:0]  bank1_base_hi_i = '0;
  logic [7:0]  bank1_base_lo_i = '0;
  logic [7:0]  mem_addr_o;
  logic        mem_rd_o;
  logic        mem_wr_o;
  logic [7:0]  mem_wdata_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic oe; logic [7:0] data; string req; } exp_t;
  exp_t exp_q[$];

  logic [7:0] model_mem [256];
  logic [6:0] model_idx [2];

  always #5 clk = ~clk;

  rtc_index_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .aen_i(aen_i),
    .io_addr_i(io_addr_i), .io_rd_i(io_rd_i), .io_wr_i(io_wr_i),
    .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .io_oe_o(io_oe_o),
    .bank1_en_i(bank1_en_i), .bank1_base_hi_i(bank1_base_hi_i),
    .bank1_base_lo_i(bank1_base_lo_i), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o)
  );

  // 0 none, 1 idx0, 2 dat0, 3 idx1, 4 dat1
  function automatic int decode(logic [15:0] a);
    logic [15:0] b1;
    b1 = {bank1_base_hi_i, bank1_base_lo_i};
    if (aen_i) return 0;
    if (a == 16'h0070) return 1;
    if (a == 16'h0071) return 2;
    if (bank1_en_i && a == b1) return 3;
    if (bank1_en_i && a == b1 + 16'd1) return 4;
    return 0;
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    int s;
    @(negedge clk);
    s = decode(a);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    if (!sys_rst_i) begin
      if (s == 1) model_idx[0] = d[6:0];
      if (s == 3) model_idx[1] = d[6:0];
      if (s == 2) model_mem[{1'b0, model_idx[0]}] = d;
      if (s == 4) model_mem[{1'b1, model_idx[1]}] = d;
    end
    @(negedge clk);
    io_wr_i = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input string req);
    int s;
    exp_t e;
    @(negedge clk);
    s = decode(a);
    e.req = req;
    e.oe = (s != 0);
    if (s == 0)          e.data = 8'h00;
    else if (sys_rst_i)  e.data = 8'hFF;
    else if (s == 1)     e.data = {1'b0, model_idx[0]};
    else if (s == 3)     e.data = {1'b0, model_idx[1]};
    else if (s == 2)     e.data = model_mem[{1'b0, model_idx[0]}];
    else                 e.data = model_mem[{1'b1, model_idx[1]}];
    exp_q.push_back(e);
    io_addr_i = a; io_rd_i = 1'b1;
    @(negedge clk);
    io_rd_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (io_rd_i) begin
        exp_t e;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL monitor: read with no expected item");
        end else begin
          e = exp_q.pop_front();
          if (io_oe_o !== e.oe || (e.oe && io_rdata_o !== e.data)) begin
            fails++;
            $display("FAIL %s addr=%h: got oe=%b data=%h, exp oe=%b data=%h",
                     e.req, io_addr_i, io_oe_o, io_rdata_o, e.oe, e.data);
          end
        end
      end
    end
  end

  task automatic check_idle(input string req);
    @(negedge clk);
    #2;
    tests++;
    if (io_oe_o !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: got oe=%b, exp oe=0", req, io_oe_o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
    model_idx[0] = '0; model_idx[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9 reset state
    check_idle("R9");
    io_read(16'h0070, "R9");
    io_read(16'h0071, "R9");

    // R1 index latch drops bit 7
    io_write(16'h0070, 8'h85);
    io_read(16'h0070, "R1");

    // R3 data store, no auto-increment
    io_write(16'h0071, 8'hA5);
    io_read(16'h0071, "R3");
    io_read(16'h0071, "R3");
    io_read(16'h0070, "R3");

    // R4 full address compare
    io_write(16'h0171, 8'h11);
    io_write(16'h1070, 8'h22);
    io_read(16'h0171, "R4");
    io_read(16'h0071, "R4");
    io_read(16'h0070, "R4");

    // R5 secondary bank
    bank1_base_hi_i = 8'h02; bank1_base_lo_i = 8'h40; bank1_en_i = 1'b1;
    io_write(16'h0240, 8'h05);
    io_write(16'h0241, 8'h3C);
    io_read(16'h0241, "R5");
    io_read(16'h0240, "R5");
    io_read(16'h0071, "R5");
    bank1_en_i = 1'b0;
    io_write(16'h0241, 8'h99);
    io_read(16'h0241, "R5");
    bank1_en_i = 1'b1;
    io_read(16'h0241, "R5");

    // R6 AEN qualifier
    aen_i = 1'b1;
    io_write(16'h0070, 8'h10);
    io_write(16'h0071, 8'hFF);
    io_read(16'h0071, "R6");
    aen_i = 1'b0;
    io_read(16'h0070, "R6");
    io_read(16'h0071, "R6");

    // R7 system reset
    sys_rst_i = 1'b1;
    io_write(16'h0070, 8'h22);
    io_write(16'h0071, 8'h77);
    io_write(16'h0241, 8'h66);
    io_read(16'h0071, "R7");
    io_read(16'h0070, "R7");
    io_read(16'h0241, "R7");
    sys_rst_i = 1'b0;
    io_read(16'h0070, "R7");
    io_read(16'h0071, "R7");
    io_read(16'h0241, "R7");

    // R8 overlap priority
    bank1_base_hi_i = 8'h00; bank1_base_lo_i = 8'h70;
    io_write(16'h0071, 8'h5A);
    io_read(16'h0071, "R8");
    bank1_base_lo_i = 8'h40; bank1_base_hi_i = 8'h02;
    io_read(16'h0241, "R8");
    bank1_base_hi_i = 8'h00; bank1_base_lo_i = 8'h6F;
    io_write(16'h006F, 8'h09);
    io_write(16'h0070, 8'h03);
    io_read(16'h006F, "R8");
    io_read(16'h0070, "R8");

    // R2 enable only during strobe
    check_idle("R2");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending, exp 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule